// File: doc/BRIEF.md
# Pixel defect map classifier

This block screens an image sensor for defective pixels. Each cycle it takes one pixel from a streamed dark exposure and the same pixel from a streamed flat-field exposure, in raster order. Start-of-frame, end-of-line and end-of-frame markers frame the stream. Two configuration inputs set the thresholds: the full-well value and the mean level of the flat exposure. The flat exposure is taken at half of full well.

A pixel is defective when either of two tests fails:

- It is hot: its dark signal is above three percent of full well.
- It is dead: its flat-field value is below half of the flat mean.

The block tracks defective pixels that touch vertically in the same column as one run. When a run ends it emits a single record with:

- the column,
- the top row of the run,
- the run length,
- a class: an isolated pixel, a small group, or a column-scale streak.

At the end of each frame it reports how many defects of each class the frame held.

Both tests are integer comparisons, so no divider is needed. Each column keeps a saturating length counter and a remembered top row. The frame height is a parameter. A run that is still open when the bottom row passes is closed on that bottom-row pixel. No flush cycles are needed between frames.

Top module: `pixel_defect_classifier`

## Requirements
- R1: A pixel is hot when `s_dark*100 > full_well*3`. Equality does not flag the pixel.
- R2: A pixel is dead when `s_flat*2 < flat_mean`. Equality does not flag the pixel.
- R3: A pixel that is hot, dead or both is defective for grouping. A healthy pixel below a healthy pixel in the same column produces no record.
- R4: A run of exactly one defective pixel is reported with `rec_type` = 1 (point).
- R5: A run of 2 to 9 defective pixels is reported with `rec_type` = 2 (cluster).
- R6: A run of 10 or more defective pixels is reported once, with `rec_type` = 3 (column).
- R7: A run is closed by the first healthy pixel below it. A run still open at row ROWS-1 is closed by that row's pixel and includes it, so every column starts the next frame empty.
- R8: The reported length saturates at 2^LW-1. The class is still chosen from the true run length.
- R9: One cycle after the pixel that closes a run, `rec_valid` is high for one cycle. At that point `rec_col` holds the column, `rec_row` the top row and `rec_len` the length.
- R10: One cycle after the end-of-frame pixel, `tot_valid` pulses. `tot_point`, `tot_cluster` and `tot_column` then hold that frame's counts. The start-of-frame marker restarts the counts.
- R11: Cycles with `s_valid` low change nothing, whatever the other stream inputs carry.
- R12: While reset is asserted, and in the cycle after it, `rec_valid` and `tot_valid` are low and the totals are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| full_well | input | PW | Full-well level in output counts |
| flat_mean | input | PW | Mean level of the flat-field exposure |
| s_valid | input | 1 | Pixel present this cycle |
| s_sof | input | 1 | First pixel of a frame |
| s_eol | input | 1 | Last pixel of a line |
| s_eof | input | 1 | Last pixel of a frame |
| s_dark | input | PW | Dark-exposure value of the pixel |
| s_flat | input | PW | Flat-exposure value of the pixel |
| rec_valid | output | 1 | Defect record present |
| rec_col | output | CW | Column of the defect |
| rec_row | output | RW | Top row of the defect |
| rec_len | output | LW | Run length, saturated |
| rec_type | output | 2 | 1 point, 2 cluster, 3 column |
| tot_valid | output | 1 | Frame totals present |
| tot_point | output | TW | Point defects in the frame |
| tot_cluster | output | TW | Cluster defects in the frame |
| tot_column | output | TW | Column defects in the frame |

## Verification
The hardest cases to reach from the ports are the corner cases of run closure:

- a run that is still open when the bottom row passes, so the closing pixel is itself defective;
- a run long enough to saturate the length counter.

The stimulus reaches both with a taller frame and a narrower counter than the defaults. One column is defective from top to bottom, and several other columns carry runs that end exactly on the last row.

Every healthy pixel sits exactly on both thresholds, and every defective pixel sits one count past a threshold. This exercises both comparison boundaries on every pixel.

Idle cycles carrying defective data and asserted markers are inserted mid-frame. They show that unqualified cycles leave the runs and the raster position untouched.

// File: rtl/pixel_defect_classifier.sv
module pixel_defect_classifier #(
  parameter int PW   = 12,
  parameter int COLS = 16,
  parameter int ROWS = 16,
  parameter int LW   = 5,
  parameter int TW   = 16,
  localparam int CW  = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] full_well,
  input  logic [PW-1:0] flat_mean,
  input  logic          s_valid,
  input  logic          s_sof,
  input  logic          s_eol,
  input  logic          s_eof,
  input  logic [PW-1:0] s_dark,
  input  logic [PW-1:0] s_flat,
  output logic          rec_valid,
  output logic [CW-1:0] rec_col,
  output logic [RW-1:0] rec_row,
  output logic [LW-1:0] rec_len,
  output logic [1:0]    rec_type,
  output logic          tot_valid,
  output logic [TW-1:0] tot_point,
  output logic [TW-1:0] tot_cluster,
  output logic [TW-1:0] tot_column
);

  localparam int XW = PW + 8;
  localparam logic [XW-1:0] K100 = XW'(100);
  localparam logic [XW-1:0] K3   = XW'(3);
  localparam logic [LW-1:0] LMAX = {LW{1'b1}};
  localparam logic [RW-1:0] LAST = RW'(ROWS - 1);

  logic [CW-1:0] col_q;
  logic [RW-1:0] row_q;
  logic [LW-1:0] run_len [COLS];
  logic [RW-1:0] run_top [COLS];
  logic [TW-1:0] acc_pt, acc_cl, acc_co;

  wire [CW-1:0] cur_col = s_sof ? '0 : col_q;
  wire [RW-1:0] cur_row = s_sof ? '0 : row_q;

  wire hot  = ({8'd0, s_dark} * K100) > ({8'd0, full_well} * K3);
  wire dead = {1'b0, s_flat, 1'b0} < {2'b00, flat_mean};
  wire flag = hot | dead;

  wire [LW-1:0] old_len = run_len[cur_col];
  wire          open_q  = old_len != '0;
  wire [LW-1:0] grown   = (old_len == LMAX) ? old_len : old_len + 1'b1;
  wire [RW-1:0] top_sel = open_q ? run_top[cur_col] : cur_row;
  wire          at_last = cur_row == LAST;

  wire          close     = s_valid & ((flag & at_last) | (~flag & open_q));
  wire [LW-1:0] close_len = flag ? grown : old_len;

  wire [RW:0]   true_len  = flag ? ({1'b0, cur_row} - {1'b0, top_sel} + 1'b1)
                                 : ({1'b0, cur_row} - {1'b0, top_sel});
  wire [1:0]    close_typ = (true_len == 1) ? 2'd1 :
                            (true_len < 10) ? 2'd2 : 2'd3;

  wire inc_pt = close & (close_typ == 2'd1);
  wire inc_cl = close & (close_typ == 2'd2);
  wire inc_co = close & (close_typ == 2'd3);

  wire [TW-1:0] nxt_pt = (s_sof ? '0 : acc_pt) + TW'(inc_pt);
  wire [TW-1:0] nxt_cl = (s_sof ? '0 : acc_cl) + TW'(inc_cl);
  wire [TW-1:0] nxt_co = (s_sof ? '0 : acc_co) + TW'(inc_co);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else if (s_valid) begin
      if (s_eol) begin
        col_q <= '0;
        row_q <= s_eof ? '0 : cur_row + 1'b1;
      end else begin
        col_q <= cur_col + 1'b1;
        row_q <= cur_row;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < COLS; i++) begin
        run_len[i] <= '0;
        run_top[i] <= '0;
      end
    end else if (s_valid) begin
      if (flag && !at_last) begin
        run_len[cur_col] <= grown;
        run_top[cur_col] <= top_sel;
      end else begin
        run_len[cur_col] <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_valid <= 1'b0;
      rec_col   <= '0;
      rec_row   <= '0;
      rec_len   <= '0;
      rec_type  <= '0;
    end else begin
      rec_valid <= close;
      if (close) begin
        rec_col  <= cur_col;
        rec_row  <= top_sel;
        rec_len  <= close_len;
        rec_type <= close_typ;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_pt      <= '0;
      acc_cl      <= '0;
      acc_co      <= '0;
      tot_valid   <= 1'b0;
      tot_point   <= '0;
      tot_cluster <= '0;
      tot_column  <= '0;
    end else begin
      tot_valid <= s_valid & s_eof;
      if (s_valid) begin
        acc_pt <= nxt_pt;
        acc_cl <= nxt_cl;
        acc_co <= nxt_co;
        if (s_eof) begin
          tot_point   <= nxt_pt;
          tot_cluster <= nxt_cl;
          tot_column  <= nxt_co;
        end
      end
    end
  end

endmodule

module pixel_defect_classifier_chk #(
  parameter int ROWS = 16,
  parameter int LW   = 5,
  parameter int TW   = 16,
  parameter int CW   = 4,
  parameter int RW   = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_valid,
  input logic          s_eof,
  input logic          rec_valid,
  input logic [RW-1:0] rec_row,
  input logic [LW-1:0] rec_len,
  input logic [1:0]    rec_type,
  input logic          tot_valid,
  input logic [TW-1:0] tot_point,
  input logic [TW-1:0] tot_cluster,
  input logic [TW-1:0] tot_column
);

  // R9
  rec_after_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> $past(s_valid));

  // R10
  tot_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tot_valid |-> $past(s_valid && s_eof));

  // R7
  run_fits_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (32'(rec_row) + 32'(rec_len)) <= ROWS);

  // R6
  column_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_type == 2'd3) |-> rec_len >= 10);

  // R8
  len_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (rec_len != '0 && rec_type != 2'd0));

  // R12
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!rec_valid && !tot_valid && tot_point == '0 &&
                tot_cluster == '0 && tot_column == '0));

endmodule

bind pixel_defect_classifier pixel_defect_classifier_chk #(
  .ROWS(ROWS), .LW(LW), .TW(TW), .CW(CW), .RW(RW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_eof(s_eof),
  .rec_valid(rec_valid), .rec_row(rec_row), .rec_len(rec_len),
  .rec_type(rec_type), .tot_valid(tot_valid), .tot_point(tot_point),
  .tot_cluster(tot_cluster), .tot_column(tot_column)
);

// File: tb/pixel_defect_classifier_test.sv
module pixel_defect_classifier_test;
  localparam int PW = 12, COLS = 4, ROWS = 20, LW = 4, TW = 16;
  localparam int CW = 2, RW = 5;
  localparam int LCAP = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PW-1:0] full_well = 12'd1000, flat_mean = 12'd400;
  logic s_valid = 0, s_sof = 0, s_eol = 0, s_eof = 0;
  logic [PW-1:0] s_dark = '0, s_flat = '0;
  logic rec_valid, tot_valid;
  logic [CW-1:0] rec_col;
  logic [RW-1:0] rec_row;
  logic [LW-1:0] rec_len;
  logic [1:0] rec_type;
  logic [TW-1:0] tot_point, tot_cluster, tot_column;

  always #4 clk = ~clk;

  pixel_defect_classifier #(.PW(PW), .COLS(COLS), .ROWS(ROWS), .LW(LW), .TW(TW)) uut (
    .clk(clk), .rst_n(rst_n), .full_well(full_well), .flat_mean(flat_mean),
    .s_valid(s_valid), .s_sof(s_sof), .s_eol(s_eol), .s_eof(s_eof),
    .s_dark(s_dark), .s_flat(s_flat), .rec_valid(rec_valid), .rec_col(rec_col),
    .rec_row(rec_row), .rec_len(rec_len), .rec_type(rec_type),
    .tot_valid(tot_valid), .tot_point(tot_point), .tot_cluster(tot_cluster),
    .tot_column(tot_column));

  typedef struct packed { logic [CW-1:0] c; logic [RW-1:0] r; logic [LW-1:0] l; logic [1:0] t; } rec_t;
  typedef struct packed { logic [TW-1:0] p; logic [TW-1:0] k; logic [TW-1:0] m; } tot_t;

  rec_t rq[$];
  tot_t tq[$];
  int checks = 0, errors = 0;
  bit done = 0;
  logic [1:0] fm [ROWS][COLS];

  task automatic clear_map();
    for (int r = 0; r < ROWS; r++) for (int c = 0; c < COLS; c++) fm[r][c] = 2'd0;
  endtask

  task automatic set_run(int c, int r0, int n, logic [1:0] code);
    for (int r = r0; r < r0 + n; r++) fm[r][c] = code;
  endtask

  // Model: a run is reported at the pixel that ends it, scanning upward for its top.
  task automatic model();
    tot_t t = '0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        int bot = -1, top, n;
        rec_t e;
        if (fm[r][c] != 0 && r == ROWS - 1) bot = r;
        else if (fm[r][c] == 0 && r > 0 && fm[r-1][c] != 0) bot = r - 1;
        if (bot >= 0) begin
          top = bot;
          while (top > 0 && fm[top-1][c] != 0) top--;
          n = bot - top + 1;
          e.c = CW'(c); e.r = RW'(top);
          e.l = LW'((n > LCAP) ? LCAP : n);
          e.t = (n == 1) ? 2'd1 : (n < 10) ? 2'd2 : 2'd3;
          if (e.t == 2'd1) t.p++; else if (e.t == 2'd2) t.k++; else t.m++;
          rq.push_back(e);
        end
      end
    tq.push_back(t);
  endtask

  // R1/R2 boundaries: healthy pixels sit exactly on both thresholds (dark 30, flat 200),
  // hot adds one count (31), dead drops one (199). R3: code 3 is both at once.
  task automatic drive_frame(bit gaps);
    model();
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        if (gaps && ((r * COLS + c) % 7 == 6)) begin
          @(negedge clk);
          s_valid = 0; s_sof = 1; s_eol = 1; s_eof = 1; s_dark = 12'd999; s_flat = 12'd0; // R11
        end
        @(negedge clk);
        s_valid = 1;
        s_sof = (r == 0 && c == 0);
        s_eol = (c == COLS - 1);
        s_eof = (r == ROWS - 1 && c == COLS - 1);
        s_dark = fm[r][c][0] ? 12'd31 : 12'd30;
        s_flat = fm[r][c][1] ? 12'd199 : 12'd200;
      end
    @(negedge clk);
    s_valid = 0; s_sof = 0; s_eol = 0; s_eof = 0;
    repeat (3) @(negedge clk);
  endtask

  always @(negedge clk) if (rst_n) begin
    if (rec_valid) begin
      rec_t got, exp;
      got = '{rec_col, rec_row, rec_len, rec_type};
      checks++;
      if (rq.size() == 0) begin
        errors++;
        $display("FAIL R9 unexpected record act=%h exp=none", got);
      end else begin
        exp = rq.pop_front();
        if (got !== exp) begin
          errors++;
          $display("FAIL %s record act col=%0d row=%0d len=%0d type=%0d exp col=%0d row=%0d len=%0d type=%0d",
                   exp.t == 1 ? "R4" : exp.t == 2 ? "R5" : "R6",
                   got.c, got.r, got.l, got.t, exp.c, exp.r, exp.l, exp.t);
        end
      end
    end
    if (tot_valid) begin
      tot_t got, exp;
      got = '{tot_point, tot_cluster, tot_column};
      checks++;
      if (tq.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected totals act=%h exp=none", got);
      end else begin
        exp = tq.pop_front();
        if (got !== exp) begin
          errors++;
          $display("FAIL R10 totals act=%0d/%0d/%0d exp=%0d/%0d/%0d",
                   got.p, got.k, got.m, exp.p, exp.k, exp.m);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rec_valid !== 0 || tot_valid !== 0 || tot_point !== 0 || tot_cluster !== 0 || tot_column !== 0) begin
      errors++;
      $display("FAIL R12 reset outputs act=%b%b%0d exp=000", rec_valid, tot_valid, tot_point);
    end
    rst_n = 1;
    @(negedge clk);

    // Frame A: point (R4), clusters of 2, 3 and 9 (R5), a streak of 10 (R6),
    // a cluster ending on the last row (R7).
    clear_map();
    set_run(0, 3, 1, 2'd1);
    set_run(0, 10, 9, 2'd2);
    set_run(1, 5, 1, 2'd1); set_run(1, 6, 1, 2'd2); set_run(1, 7, 1, 2'd3);
    set_run(1, 10, 2, 2'd1);
    set_run(2, 2, 10, 2'd3);
    set_run(3, 15, 5, 2'd2);
    drive_frame(0);

    // Frame B: full-height column saturates the length at 15 (R8),
    // a point on the last row (R7), idle cycles with junk (R11).
    clear_map();
    set_run(3, 0, ROWS, 2'd1);
    set_run(0, 18, 2, 2'd2);
    set_run(1, 19, 1, 2'd3);
    set_run(2, 0, 1, 2'd2);
    drive_frame(1);

    // Frame C: all pixels on the thresholds, no records, zero totals (R1, R2, R3).
    clear_map();
    drive_frame(1);

    repeat (5) @(negedge clk);
    checks++;
    if (rq.size() != 0 || tq.size() != 0) begin
      errors++;
      $display("FAIL R9 missing outputs act=%0d/%0d exp=0/0", rq.size(), tq.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule